// File: doc/BRIEF.md
# Shared-MAC Second-Order Recursive Low-Pass Section

This block computes one second-order recursive low-pass section in the canonical two-delay form. All arithmetic runs on a single signed multiplier and a single accumulator. A small sequencer steps the pair through a fixed schedule for each sample. First it builds the new internal state from the input sample and two feedback products. Next it builds the output from three feed-forward products. Last it publishes the result and moves the delay line along by one place.

The multiplier takes a 16-bit coefficient and a 12-bit data operand. The data operand comes from one of four places: the external sample, the upper twelve bits of the accumulator, or either of the two stored states. The new state is therefore a truncation of the accumulator, fed straight back through the same multiplier port that the sample uses. A host presents one sample with a single-cycle strobe, waits for the completion pulse, and then reads the result.

Top module: `biquad_tm`

## Requirements
- R1: While rst_ni is low, y_o and done_o are zero. After reset, both stored states are zero, so a first sample of 1000 produces y_o = 1608000 with out_en_i high.
- R2: The state is formed as s = acc[27:16] of a 28-bit two's-complement accumulator. The accumulator holds 4·(16384·x + 7402·s1 + 8176·s2), where s1 and s2 are the stored states and x is the signed 12-bit sample. Coefficients are signed 16-bit values with 14 fractional bits. Overflow wraps modulo 2^28 with no saturation.
- R3: The result held for output is y = 4·(201·s + 403·s1 + 201·s2), wrapped to 28 bits, using the same states as R2.
- R4: Once a result is published, the older state takes the previous value of the newer state, and the newer state takes s. An input of 0 directly after 1000 from reset therefore yields y_o = 3949208.
- R5: done_o is high for exactly one cycle. It goes high 10 rising edges after the edge that accepts the sample, and the new result is visible on y_o in that same cycle.
- R6: A strobe seen while a computation is in progress is ignored. It changes neither the result nor the states, and it produces no extra done_o pulse.
- R7: With out_en_i high, y_o shows the held result shifted left by one bit with a zero in bit 0. With out_en_i low, y_o is zero. The held result changes only when a new result is published.
- R8: A strobe in the same cycle that done_o is high is accepted as the next sample.
- R9: Inputs at full scale over many samples drive the state and the accumulator past their ranges. The outputs then follow the wrapped truncation of R2 and R3 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | One-cycle strobe that presents a new sample |
| sample_i | input | 12 | Signed input sample |
| out_en_i | input | 1 | Drive the result onto y_o when high |
| y_o | output | 28 | Result shifted left by one, or zero when disabled |
| done_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Two actions can fall in the same cycle. One is publishing a result, which latches it and shifts the delay line. The other is accepting the next sample, which issues the sample product. The bench provokes this by raising the strobe in the very cycle done_o is high, which happens in several table vectors that have no gap. It then judges both samples' outputs against a bit-exact 28-bit model: if the shift and the new sample's feedback reads were interleaved wrongly, the second output would depart from the model. A strobe raised partway through a computation is also checked. It must leave both the following result and the done_o count untouched.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  typedef enum logic [2:0] {C_ONE, C_FB1, C_FB2, C_FF0, C_FF1, C_FF2} coef_sel_e;
  typedef enum logic [1:0] {D_SAMPLE, D_ACC, D_ST1, D_ST2} data_sel_e;
  typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_ADD} acc_op_e;

  localparam int STEP_W     = 4;
  localparam int ST_FB1     = 1;
  localparam int ST_FB2     = 2;
  localparam int ST_FBA1    = 3;
  localparam int ST_FBA2    = 4;
  localparam int ST_FF0     = 5;
  localparam int ST_FF1     = 6;
  localparam int ST_FF2     = 7;
  localparam int ST_FFA1    = 8;
  localparam int ST_FFA2    = 9;
  localparam int ST_PUBLISH = 10;
endpackage

// File: rtl/biquad_mul.sv
module biquad_mul #(
  parameter int COEF_W = 16,
  parameter int DATA_W = 12,
  localparam int PROD_W = COEF_W + DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [COEF_W-1:0] coef_q;
  logic signed [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      data_q <= '0;
      prod_o <= '0;
    end else begin
      coef_q <= coef_i;
      data_q <= data_i;
      prod_o <= PROD_W'(coef_q) * PROD_W'(data_q);
    end
  end
endmodule

// File: rtl/biquad_acc.sv
module biquad_acc
  import biquad_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int SHIFT = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  acc_op_e                 op_i,
  input  logic signed [ACC_W-1:0] prod_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] addend;
  assign addend = prod_i <<< SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= '0;
    else begin
      case (op_i)
        ACC_LOAD: acc_o <= addend;
        ACC_ADD:  acc_o <= acc_o + addend;
        default:  acc_o <= acc_o;
      endcase
    end
  end

  a_r2_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == ACC_HOLD) |=> $stable(acc_o));
endmodule

// File: rtl/biquad_seq.sv
module biquad_seq
  import biquad_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  output coef_sel_e coef_sel_o,
  output data_sel_e data_sel_o,
  output acc_op_e   acc_op_o,
  output logic      st0_en_o,
  output logic      publish_o,
  output logic      done_o
);
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              accept;

  assign accept = !busy_q && start_i;

  always_comb begin
    coef_sel_o = C_ONE;
    data_sel_o = D_SAMPLE;
    acc_op_o   = ACC_HOLD;
    st0_en_o   = 1'b0;
    publish_o  = 1'b0;
    if (busy_q) begin
      case (int'(step_q))
        ST_FB1:     begin coef_sel_o = C_FB1; data_sel_o = D_ST1; end
        ST_FB2:     begin coef_sel_o = C_FB2; data_sel_o = D_ST2; acc_op_o = ACC_LOAD; end
        ST_FBA1:    acc_op_o = ACC_ADD;
        ST_FBA2:    acc_op_o = ACC_ADD;
        ST_FF0:     begin coef_sel_o = C_FF0; data_sel_o = D_ACC; st0_en_o = 1'b1; end
        ST_FF1:     begin coef_sel_o = C_FF1; data_sel_o = D_ST1; end
        ST_FF2:     begin coef_sel_o = C_FF2; data_sel_o = D_ST2; acc_op_o = ACC_LOAD; end
        ST_FFA1:    acc_op_o = ACC_ADD;
        ST_FFA2:    acc_op_o = ACC_ADD;
        ST_PUBLISH: publish_o = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= publish_o;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= STEP_W'(ST_FB1);
      end else if (busy_q) begin
        if (int'(step_q) == ST_PUBLISH) begin
          busy_q <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_q);
  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (int'(step_q) != ST_FB1));
endmodule

// File: rtl/biquad_tm.sv
module biquad_tm
  import biquad_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int COEF_W   = 16,
  parameter int COEF_FRAC = 14,
  parameter logic signed [COEF_W-1:0] FB1_COEF = 16'sd7402,
  parameter logic signed [COEF_W-1:0] FB2_COEF = 16'sd8176,
  parameter logic signed [COEF_W-1:0] FF0_COEF = 16'sd201,
  parameter logic signed [COEF_W-1:0] FF1_COEF = 16'sd403,
  parameter logic signed [COEF_W-1:0] FF2_COEF = 16'sd201,
  localparam int ACC_W = COEF_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              out_en_i,
  output logic [ACC_W-1:0]  y_o,
  output logic              done_o
);
  localparam int SHIFT  = ACC_W - DATA_W - COEF_FRAC;
  localparam int NSTATE = 2;
  localparam logic signed [COEF_W-1:0] ONE_COEF = COEF_W'(1 << COEF_FRAC);

  coef_sel_e coef_sel;
  data_sel_e data_sel;
  acc_op_e   acc_op;
  logic      st0_en, publish;

  logic signed [COEF_W-1:0] coef_mux;
  logic signed [DATA_W-1:0] data_mux;
  logic signed [ACC_W-1:0]  prod, acc;
  logic signed [DATA_W-1:0] acc_top;
  logic signed [DATA_W-1:0] st0_q;
  logic signed [DATA_W-1:0] st_q [NSTATE];
  logic        [ACC_W-1:0]  y_q;

  assign acc_top = acc[ACC_W-1 -: DATA_W];

  biquad_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (sample_valid_i),
    .coef_sel_o (coef_sel),
    .data_sel_o (data_sel),
    .acc_op_o   (acc_op),
    .st0_en_o   (st0_en),
    .publish_o  (publish),
    .done_o     (done_o)
  );

  always_comb begin
    case (coef_sel)
      C_FB1:   coef_mux = FB1_COEF;
      C_FB2:   coef_mux = FB2_COEF;
      C_FF0:   coef_mux = FF0_COEF;
      C_FF1:   coef_mux = FF1_COEF;
      C_FF2:   coef_mux = FF2_COEF;
      default: coef_mux = ONE_COEF;
    endcase
    case (data_sel)
      D_ACC:   data_mux = acc_top;
      D_ST1:   data_mux = st_q[0];
      D_ST2:   data_mux = st_q[1];
      default: data_mux = sample_i;
    endcase
  end

  biquad_mul #(.COEF_W(COEF_W), .DATA_W(DATA_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .coef_i (coef_mux),
    .data_i (data_mux),
    .prod_o (prod)
  );

  biquad_acc #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (acc_op),
    .prod_i (prod),
    .acc_o  (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st0_q <= '0;
      y_q   <= '0;
      for (int k = 0; k < NSTATE; k++) st_q[k] <= '0;
    end else begin
      if (st0_en) st0_q <= acc_top;
      if (publish) begin
        y_q     <= acc;
        st_q[0] <= st0_q;
        for (int k = 1; k < NSTATE; k++) st_q[k] <= st_q[k-1];
      end
    end
  end

  assign y_o = out_en_i ? {y_q[ACC_W-2:0], 1'b0} : '0;

  a_r4_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    publish |=> (st_q[1] == $past(st_q[0])) && (st_q[0] == $past(st0_q)));
  a_r7_y_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !publish |=> $stable(y_q));
  a_r5_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    publish |=> done_o);
endmodule

// File: tb/sim_biquad_tm.sv
module sim_biquad_tm;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        out_en_i = 1'b1;
  logic [27:0] y_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  biquad_tm u0 (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sample_valid_i (sample_valid_i),
    .sample_i       (sample_i),
    .out_en_i       (out_en_i),
    .y_o            (y_o),
    .done_o         (done_o)
  );

  localparam logic signed [15:0] K_ONE = 16'sd16384;
  localparam logic signed [15:0] K_FB1 = 16'sd7402;
  localparam logic signed [15:0] K_FB2 = 16'sd8176;
  localparam logic signed [15:0] K_FF0 = 16'sd201;
  localparam logic signed [15:0] K_FF1 = 16'sd403;
  localparam logic signed [15:0] K_FF2 = 16'sd201;

  localparam int NV = 12;
  localparam logic signed [11:0] VEC_X [NV] = '{12'sd1000, 12'sd0, 12'sd0, -12'sd500,
    12'sd300, 12'sd2047, 12'sd2047, 12'sd2047, 12'sd2047, -12'sd2048, -12'sd2048, 12'sd0};
  localparam int VEC_GAP [NV] = '{3, 0, 2, 0, 5, 0, 0, 1, 0, 0, 2, 0};
  localparam bit VEC_OE  [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1, 1};

  logic signed [11:0] m_s1 = '0, m_s2 = '0;
  logic        [27:0] m_y = '0;

  function automatic logic signed [27:0] term(input logic signed [15:0] c,
                                              input logic signed [11:0] d);
    logic signed [27:0] p;
    p = 28'(c) * 28'(d);
    return p <<< 2;
  endfunction

  task automatic model_step(input logic signed [11:0] x);
    logic signed [27:0] a;
    logic signed [11:0] s;
    a = term(K_ONE, x) + term(K_FB1, m_s1) + term(K_FB2, m_s2);
    s = a[27:16];
    a = term(K_FF0, s) + term(K_FF1, m_s1) + term(K_FF2, m_s2);
    m_y  = a;
    m_s2 = m_s1;
    m_s1 = s;
  endtask

  function automatic logic [27:0] shown(input bit oe, input logic [27:0] v);
    return oe ? {v[26:0], 1'b0} : 28'd0;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge, returns at the negedge where done_o is high.
  task automatic run_sample(input logic signed [11:0] x, input bit oe, input string req);
    int cnt = 0;
    out_en_i = oe;
    sample_i = x;
    sample_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_valid_i = 1'b0;
    model_step(x);
    while (!done_o && cnt < 40) begin
      @(posedge clk); @(negedge clk);
      cnt++;
    end
    chk({req, " R5 latency"}, cnt, 10);
    chk({req, " value"}, longint'(y_o), longint'(shown(oe, m_y)));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dones;
    repeat (3) @(negedge clk);
    chk("R1 reset y_o", longint'(y_o), 0);
    chk("R1 reset done_o", longint'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // Table walk: gap 0 means the next strobe lands in the done cycle (R8); R2 R3 R4 R9 by model.
    for (int i = 0; i < NV; i++) begin
      run_sample(VEC_X[i], VEC_OE[i], $sformatf("R2/R3/R8/R9 vec%0d", i));
      if (VEC_GAP[i] > 0) begin
        @(posedge clk); @(negedge clk);
        chk("R5 single pulse", longint'(done_o), 0);
        repeat (VEC_GAP[i] - 1) @(negedge clk);
      end
    end

    // R7: output enable and hold
    repeat (3) @(negedge clk);
    out_en_i = 1'b1;
    #1 chk("R7 held result", longint'(y_o), longint'(shown(1'b1, m_y)));
    out_en_i = 1'b0;
    #1 chk("R7 disabled zero", longint'(y_o), 0);
    out_en_i = 1'b1;
    #1 chk("R7 re-enabled", longint'(y_o), longint'(shown(1'b1, m_y)));
    @(negedge clk);

    // R6: strobe while busy is ignored
    out_en_i = 1'b1;
    sample_i = 12'sd100;
    sample_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_valid_i = 1'b0;
    model_step(12'sd100);
    repeat (3) @(negedge clk);
    sample_i = -12'sd777;
    sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
    dones = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (done_o) begin
        dones++;
        if (dones == 1) chk("R6 value unaffected", longint'(y_o), longint'(shown(1'b1, m_y)));
      end
    end
    chk("R6 one done only", dones, 1);
    run_sample(12'sd50, 1'b1, "R6 states unaffected");

    // R1: reset mid-computation, then hand-computed impulse response (R3, R4)
    @(negedge clk);
    sample_i = 12'sd999;
    sample_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    sample_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1 chk("R1 mid reset y_o", longint'(y_o), 0);
    chk("R1 mid reset done_o", longint'(done_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_s1 = '0; m_s2 = '0; m_y = '0;
    @(negedge clk);
    run_sample(12'sd1000, 1'b1, "R1 states zero");
    chk("R3 impulse first", longint'(y_o), 1608000);
    run_sample(12'sd0, 1'b1, "R4 shift");
    chk("R4 impulse second", longint'(y_o), 3949208);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule